// File: doc/BRIEF.md
# Filtered I2C Bus Condition Monitor

This block watches the two wires of an I2C bus from inside a synchronous design. Each raw line is brought into the bus clock domain through a two-stage synchroniser and then through a glitch filter whose width is programmed as a number of clock cycles. A level change reaches the filtered line only after it has held for one cycle more than the programmed width, so every pulse up to and including the programmed width is absorbed. A width of zero turns the filter into a plain one-register stage.

The filtered lines drive a condition detector. A falling data line while the clock line stays high is a START, and a rising data line while the clock line stays high is a STOP. The detector produces one-cycle strobes for START, repeated START and STOP, and it keeps a bus-busy level that runs from a START to the next STOP. A small register port sets the filter width and the STOP interrupt enable, and it reads and clears a sticky STOP flag. The interrupt is a level: the flag ANDed with its enable.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A low or high pulse on either raw line that lasts no more than W bus clocks, where W is the programmed filter width, never changes the matching filtered output.
- R2: A level change on a raw line that holds for W+1 or more bus clocks appears on the matching filtered output.
- R3: With W equal to 0, a single-cycle pulse on a raw line reaches the filtered output.
- R4: A falling filtered data line while the filtered clock line is high and was high one cycle before gives a START strobe that is high for exactly one cycle.
- R5: A rising filtered data line while the filtered clock line is high and was high one cycle before gives a STOP strobe that is high for exactly one cycle.
- R6: Data line changes made while the clock line is low produce neither a START nor a STOP strobe.
- R7: The busy output rises with a START strobe and falls with a STOP strobe, and stays unchanged otherwise.
- R8: A START that occurs while busy is high also raises the repeated-START strobe for that one cycle; a START seen while idle does not.
- R9: A STOP sets a sticky flag; writing register 1 with data bit 0 set clears it, and writing register 1 with bit 0 clear leaves it set.
- R10: The interrupt output is high exactly when the STOP flag and the interrupt enable (register 1 bit 1) are both set.
- R11: After reset, busy, the STOP flag, the interrupt enable and the interrupt are 0, the filter width is 0, and both filtered lines are 1.
- R12: Register 0 holds the filter width in bits [3:0]; register 1 reads the STOP flag in bit 0, the interrupt enable in bit 1 and busy in bit 2, all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Unsynchronised clock line from the pad |
| sda_raw | input | 1 | Unsynchronised data line from the pad |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |
| start_pulse | output | 1 | One-cycle START strobe |
| rstart_pulse | output | 1 | One-cycle repeated START strobe |
| stop_pulse | output | 1 | One-cycle STOP strobe |
| bus_busy | output | 1 | High between a START and the next STOP |
| stop_flag | output | 1 | Sticky STOP flag |
| irq | output | 1 | Level interrupt, flag AND enable |

## Verification
The filter is swept over every width from 0 to 5 against pulse lengths from 1 to 7 cycles on the clock line, which separates an off-by-one in the absorb limit from a correct limit and shows the zero-width bypass. A data-line pulse with the clock line high at the boundary lengths W and W+1 tells an absorbed glitch from a real START and STOP pair. A scripted transfer with data changes under a low clock, a repeated START and a final STOP separates condition decoding from plain edge detection and checks busy tracking, while flag writes with bit 0 set and clear distinguish write-one-to-clear from plain writes and show the interrupt gating.

// File: rtl/i2cmon_pkg.sv
// Shared constants and types for the bus condition monitor.
package i2cmon_pkg;
    // Register select values
    localparam logic REG_WIDTH = 1'b0;
    localparam logic REG_STAT  = 1'b1;

    // Bit positions inside the status/control register
    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_IE_BIT   = 1;
    localparam int STAT_BUSY_BIT = 2;

    // One sample of the two bus lines
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;
endpackage

// File: rtl/i2cmon_sync.sv
// Multi-stage synchroniser for one asynchronous line.
// Assumes: the line idles high, so every stage resets to 1.
module i2cmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2cmon_filter.sv
// Glitch filter for one synchronised line.
// A difference between input and output must persist for width+1
// consecutive cycles before the output takes the input value.
// Assumes: d_in is already in the clk domain; width may change at any time.
module i2cmon_filter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] width,
    input  logic             d_in,
    output logic             d_out
);
    logic [CNT_W-1:0] run_q;
    logic             out_q;
    logic             differs;

    assign differs = (d_in != out_q);

    // Count cycles of disagreement and commit once the run is long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            run_q <= '0;
        end else if (differs) begin
            if (run_q >= width) begin
                out_q <= d_in;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign d_out = out_q;

    // R1: when input agrees with output, the output holds next cycle
    a_r1_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (d_in == out_q) |=> $stable(out_q));

    // R2: any output change takes the value the input had before the edge
    a_r2_change_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> (out_q == $past(d_in)));
endmodule

// File: rtl/i2cmon_cond.sv
// START / STOP condition detector on filtered lines.
// Produces registered one-cycle strobes and the busy level.
// Assumes: inputs are glitch-free and idle high after reset.
module i2cmon_cond
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t lines,
    output logic       start_o,
    output logic       rstart_o,
    output logic       stop_o,
    output logic       busy_o
);
    bus_lines_t prev_q;
    logic       saw_start;
    logic       saw_stop;

    // Conditions need SCL high on both the old and new sample
    assign saw_start = prev_q.scl && lines.scl &&  prev_q.sda && !lines.sda;
    assign saw_stop  = prev_q.scl && lines.scl && !prev_q.sda &&  lines.sda;

    // Remember last sample of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= lines;
        end
    end

    // Register the strobes and track the busy span
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            rstart_o <= 1'b0;
            stop_o   <= 1'b0;
            busy_o   <= 1'b0;
        end else begin
            start_o  <= saw_start;
            rstart_o <= saw_start && busy_o;
            stop_o   <= saw_stop;
            if (saw_start) begin
                busy_o <= 1'b1;
            end else if (saw_stop) begin
                busy_o <= 1'b0;
            end
        end
    end

    // R4: START and STOP can never be reported together
    a_r4_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R5: a STOP strobe always lasts a single cycle
    a_r5_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R7: busy only rises together with a START strobe
    a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> start_o);

    // R7: busy only falls together with a STOP strobe
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> stop_o);

    // R8: repeated START is a subset of START
    a_r8_rstart_subset: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_o |-> start_o);
endmodule

// File: rtl/i2cmon_regs.sv
// Register file: filter width, STOP interrupt enable, sticky STOP flag.
// Assumes: a flag set event in the same cycle as a clear write wins.
module i2cmon_regs
    import i2cmon_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              stop_evt,
    input  logic              busy,
    output logic [CNT_W-1:0]  width_o,
    output logic              flag_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] width_q;
    logic             ie_q;
    logic             flag_q;
    logic             clr_req;

    assign clr_req = wr && (addr == REG_STAT) && wdata[STAT_FLAG_BIT];

    // Configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
            ie_q    <= 1'b0;
        end else if (wr) begin
            if (addr == REG_WIDTH) begin
                width_q <= wdata[CNT_W-1:0];
            end else begin
                ie_q <= wdata[STAT_IE_BIT];
            end
        end
    end

    // Sticky STOP flag, cleared by writing a one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (stop_evt) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == REG_WIDTH) begin
            rdata[CNT_W-1:0] = width_q;
        end else begin
            rdata[STAT_FLAG_BIT] = flag_q;
            rdata[STAT_IE_BIT]   = ie_q;
            rdata[STAT_BUSY_BIT] = busy;
        end
    end

    assign width_o = width_q;
    assign flag_o  = flag_q;
    assign irq_o   = flag_q && ie_q;

    // R9: without a clear write the flag never drops
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    // R9: a STOP event always leaves the flag set
    a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> flag_q);
endmodule

// File: rtl/i2c_bus_monitor.sv
// Top level: synchronise and filter both bus lines, detect bus
// conditions, and expose a small register port.
// Assumes: raw lines are asynchronous; reset is synchronous, active low.
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_raw,
    input  logic              sda_raw,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              scl_filt,
    output logic              sda_filt,
    output logic              start_pulse,
    output logic              rstart_pulse,
    output logic              stop_pulse,
    output logic              bus_busy,
    output logic              stop_flag,
    output logic              irq
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_vec;
    logic [NLINES-1:0] sync_vec;
    logic [NLINES-1:0] filt_vec;
    logic [CNT_W-1:0]  width;
    bus_lines_t        clean;

    assign raw_vec = {scl_raw, sda_raw};

    // One synchroniser and one filter per bus line
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (raw_vec[i]),
            .d_out (sync_vec[i])
        );
        i2cmon_filter #(.CNT_W(CNT_W)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .width (width),
            .d_in  (sync_vec[i]),
            .d_out (filt_vec[i])
        );
    end

    assign clean.scl = filt_vec[1];
    assign clean.sda = filt_vec[0];
    assign scl_filt  = clean.scl;
    assign sda_filt  = clean.sda;

    i2cmon_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (clean),
        .start_o  (start_pulse),
        .rstart_o (rstart_pulse),
        .stop_o   (stop_pulse),
        .busy_o   (bus_busy)
    );

    i2cmon_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .stop_evt (stop_pulse),
        .busy     (bus_busy),
        .width_o  (width),
        .flag_o   (stop_flag),
        .irq_o    (irq)
    );

    // R10: interrupt never asserts without the sticky flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stop_flag);

    // R11: outputs one cycle after reset release are idle
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!bus_busy && !stop_flag && !irq && scl_filt && sda_filt));
endmodule

// File: tb/i2c_bus_monitor_test.sv
module i2c_bus_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_filt, sda_filt, start_pulse, rstart_pulse, stop_pulse;
    logic       bus_busy, stop_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // cycle counters of outputs
    int scl_toggles = 0, sda_toggles = 0;
    int n_start = 0, n_rstart = 0, n_stop = 0;
    logic scl_last = 1'b1, sda_last = 1'b1;

    always #5 clk = ~clk;

    i2c_bus_monitor uut (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
        .stop_pulse(stop_pulse), .bus_busy(bus_busy), .stop_flag(stop_flag),
        .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_filt != scl_last) scl_toggles++;
            if (sda_filt != sda_last) sda_toggles++;
            if (start_pulse)  n_start++;
            if (rstart_pulse) n_rstart++;
            if (stop_pulse)   n_stop++;
        end
        scl_last = scl_filt;
        sda_last = sda_filt;
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_scl(input logic v); @(negedge clk); scl_raw = v; idle(12); endtask
    task automatic set_sda(input logic v); @(negedge clk); sda_raw = v; idle(12); endtask

    initial begin
        logic [7:0] rd;
        int t0, s0, p0, r0;
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk("R11 busy", bus_busy, 0);
        chk("R11 flag", stop_flag, 0);
        chk("R11 irq", irq, 0);
        chk("R11 scl_filt", scl_filt, 1);
        chk("R11 sda_filt", sda_filt, 1);
        read_reg(1'b0, rd); chk("R11 width reg", rd, 0);
        read_reg(1'b1, rd); chk("R11 status reg", rd, 0);

        // R1 R2 R3: sweep width against SCL pulse length
        for (int w = 0; w <= 5; w++) begin
            write_reg(1'b0, 8'(w));
            read_reg(1'b0, rd); chk("R12 width readback", rd, w);
            for (int len = 1; len <= 7; len++) begin
                t0 = scl_toggles;
                @(negedge clk); scl_raw = 1'b0;
                repeat (len) @(negedge clk);
                scl_raw = 1'b1;
                idle(w + 10);
                if (len <= w) chk("R1 absorb", scl_toggles - t0, 0);
                else if (w == 0) chk("R3 bypass", scl_toggles - t0, 2);
                else chk("R2 pass", scl_toggles - t0, 2);
            end
        end

        // R1/R4/R5: SDA pulse with SCL high at boundary lengths, W=3
        write_reg(1'b0, 8'd3);
        for (int len = 3; len <= 4; len++) begin
            s0 = n_start; p0 = n_stop; t0 = sda_toggles;
            @(negedge clk); sda_raw = 1'b0;
            repeat (len) @(negedge clk);
            sda_raw = 1'b1;
            idle(15);
            chk(len == 3 ? "R1 sda absorb" : "R2 sda pass", sda_toggles - t0, len == 3 ? 0 : 2);
            chk("R4 start strobe", n_start - s0, len == 3 ? 0 : 1);
            chk("R5 stop strobe", n_stop - p0, len == 3 ? 0 : 1);
        end
        chk("R7 busy after short frame", bus_busy, 0);
        chk("R9 flag set by stop", stop_flag, 1);
        write_reg(1'b1, 8'h01);
        chk("R9 flag cleared", stop_flag, 0);

        // R6: data moves while clock low, W=0
        write_reg(1'b0, 8'd0);
        s0 = n_start; p0 = n_stop;
        set_scl(1'b0); set_sda(1'b0); set_sda(1'b1); set_scl(1'b1);
        chk("R6 no start", n_start - s0, 0);
        chk("R6 no stop", n_stop - p0, 0);
        chk("R6 flag untouched", stop_flag, 0);

        // R4 R7 R8: START, repeated START, STOP
        s0 = n_start; r0 = n_rstart; p0 = n_stop;
        set_sda(1'b0);
        chk("R4 start count", n_start - s0, 1);
        chk("R8 no rstart from idle", n_rstart - r0, 0);
        chk("R7 busy set", bus_busy, 1);
        set_scl(1'b0); set_sda(1'b1); set_scl(1'b1); set_sda(1'b0);
        chk("R8 rstart count", n_rstart - r0, 1);
        chk("R4 start count total", n_start - s0, 2);
        chk("R7 busy held", bus_busy, 1);
        read_reg(1'b1, rd); chk("R12 busy bit", rd, 8'h04);
        set_scl(1'b0); set_scl(1'b1); set_sda(1'b1);
        chk("R5 stop count", n_stop - p0, 1);
        chk("R7 busy cleared", bus_busy, 0);

        // R9 R10: flag, enable, interrupt
        chk("R9 flag after stop", stop_flag, 1);
        chk("R10 irq gated off", irq, 0);
        write_reg(1'b1, 8'h02);
        chk("R9 zero write keeps flag", stop_flag, 1);
        chk("R10 irq on", irq, 1);
        read_reg(1'b1, rd); chk("R12 status flag+ie", rd, 8'h03);
        write_reg(1'b1, 8'h03);
        chk("R9 flag cleared by one", stop_flag, 0);
        chk("R10 irq off", irq, 0);
        read_reg(1'b1, rd); chk("R12 status ie only", rd, 8'h02);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule